// File: doc/BRIEF.md
# Power-of-Two Clock Enable Generator

This block produces every slow timing rate inside a chip from one fast reference clock. No new clock nets are created. Each rate is a one-cycle enable pulse in the reference clock domain, and downstream logic qualifies its flops with that pulse.

- **Base rate.** A fixed divide-by-four prescaler produces the base-rate strobe. It serves the converter, the filter and the engine memory.
- **Processor rate.** A run-time divider produces the processor-rate strobe at the base rate divided by 2 to the power of a 3-bit select. The select resets to 0, so the processor starts at the full base rate. At select 7 the processor runs at 1/128 of the base rate.
- **Debug rate.** A companion strobe runs at twice the processor rate for a debug port. A disable input can silence it.

A change of the select is picked up only where a processor period ends. The period already running always completes at its old length. No pulse on any output is ever cut short.

Top module: `clkgen_top`

## Requirements
- R1: While `rstN` is low, `baseEn`, `cpuEn` and `dbgEn` are all 0. After release, `baseEn` is high for exactly one reference cycle in every 4. Its first pulse comes in the fourth cycle after the release cycle, counting the release cycle as the first.
- R2: With a steady select s, `cpuEn` is high for exactly one reference cycle in every 4·2^s cycles.
- R3: The active select is 0 after reset, so `cpuEn` then pulses every 4 reference cycles, together with every `baseEn` pulse.
- R4: With select 7, `cpuEn` pulses once every 512 reference cycles (base rate / 128).
- R5: With `dbgDisable` low and steady select s, `dbgEn` pulses once every 2·2^s reference cycles. One pulse falls in the same cycle as each `cpuEn` pulse, and one falls exactly midway between two `cpuEn` pulses.
- R6: With select 0 and `dbgDisable` low, `dbgEn` is high every second reference cycle.
- R7: While `dbgDisable` is high, `dbgEn` is 0 in that same cycle. `baseEn` and `cpuEn` are unaffected.
- R8: `divSel` is sampled only on the clock edge that ends a cycle in which `cpuEn` is high. The new value sets the length of the next processor period. A period in progress runs to its full length at the old select, and `baseEn` is unaffected.
- R9: Every `cpuEn` pulse coincides with a `baseEn` pulse, for every select value and across select changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | SEL_W (3) | Processor divide select s; rate = base / 2^s |
| dbgDisable | input | 1 | High suppresses the twice-rate debug strobe |
| baseEn | output | 1 | Base-rate enable, one cycle in PRE_DIV (4) |
| cpuEn | output | 1 | Processor-rate enable |
| dbgEn | output | 1 | Debug enable at twice the processor rate |

## Verification
The embedded properties check the following on every cycle:
- each `cpuEn` pulse lies on a `baseEn` pulse;
- `cpuEn` and `baseEn` are never high in two consecutive cycles;
- the active select changes only after a `cpuEn` cycle;
- the period counter stays within the current period;
- an enabled debug strobe is present at each `cpuEn`.

Only the bench scenarios can show the following:
- the actual period lengths for selects 0, 1, 2, 3, 5 and 7;
- the midpoint position of the debug pulses;
- where a mid-period select change takes effect;
- that asserting the disable silences the debug strobe without disturbing the other two outputs.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // Strobes the prescaler control hands to the divider datapath.
  typedef struct packed {
    logic baseTick;  // last reference cycle of a base period
    logic midTick;   // middle reference cycle of a base period
  } clkStrobe_t;

endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  output clkStrobe_t strb
);

  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int MID   = PRE_DIV / 2 - 1;
  localparam int LAST  = PRE_DIV - 1;

  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (preCnt == PRE_W'(LAST)) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_comb begin
    strb.baseTick = (preCnt == PRE_W'(LAST));
    strb.midTick  = (preCnt == PRE_W'(MID));
  end

  // R1: a base strobe is never followed by another in the next cycle
  a_r1_base_gap: assert property (@(posedge clk) disable iff (!rstN)
    strb.baseTick |=> !strb.baseTick);

endmodule

// File: rtl/clkgen_dp.sv
module clkgen_dp
  import clkgen_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  clkStrobe_t       strb,
  input  logic [SEL_W-1:0] divSel,
  output logic             cpuHit,
  output logic             dbgHit
);

  localparam int CNT_W = (2 ** SEL_W) - 1;

  logic [SEL_W-1:0] activeSel;
  logic [CNT_W-1:0] cpuCnt;
  logic [CNT_W-1:0] cpuMask;
  logic [CNT_W-1:0] dbgMask;

  function automatic logic [CNT_W-1:0] lowMask(input logic [SEL_W-1:0] s);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(s)) m[i] = 1'b1;
    end
    return m;
  endfunction

  always_comb begin
    cpuMask = lowMask(activeSel);
    dbgMask = cpuMask >> 1;
    cpuHit  = strb.baseTick && (cpuCnt == cpuMask);
    if (activeSel == '0) begin
      dbgHit = strb.baseTick || strb.midTick;
    end else begin
      dbgHit = strb.baseTick && ((cpuCnt & dbgMask) == dbgMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuCnt    <= '0;
      activeSel <= '0;
    end else if (strb.baseTick) begin
      if (cpuHit) begin
        cpuCnt    <= '0;
        activeSel <= divSel;
      end else begin
        cpuCnt <= cpuCnt + CNT_W'(1);
      end
    end
  end

  // R2: processor strobe is one cycle wide
  a_r2_cpu_single: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |=> !cpuHit);

  // R2: base-tick counter never runs past the current period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cpuCnt <= cpuMask);

  // R8: active select only moves after a processor strobe
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cpuHit |=> $stable(activeSel));

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int PRE_DIV = 4,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             dbgDisable,
  output logic             baseEn,
  output logic             cpuEn,
  output logic             dbgEn
);

  clkStrobe_t strb;
  logic       dbgRaw;

  clkgen_ctrl #(.PRE_DIV(PRE_DIV)) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  clkgen_dp #(.SEL_W(SEL_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .divSel (divSel),
    .cpuHit (cpuEn),
    .dbgHit (dbgRaw)
  );

  assign baseEn = strb.baseTick;
  assign dbgEn  = dbgRaw && !dbgDisable;

  // R9: processor strobe always lands on a base strobe
  a_r9_cpu_on_base: assert property (@(posedge clk) disable iff (!rstN)
    cpuEn |-> baseEn);

  // R5: enabled debug strobe is present at every processor strobe
  a_r5_dbg_at_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (cpuEn && !dbgDisable) |-> dbgEn);

endmodule

// File: tb/test_clkgen_top.sv
module test_clkgen_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] divSel = 3'd0;
  logic       dbgDisable = 1'b0;
  logic       baseEn, cpuEn, dbgEn;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  logic [2:0] expQ[$];
  string      tagQ[$];

  clkgen_top i_clkgen_top (
    .clk(clk), .rstN(rstN), .divSel(divSel), .dbgDisable(dbgDisable),
    .baseEn(baseEn), .cpuEn(cpuEn), .dbgEn(dbgEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: period-based expectation, pushed once per cycle.
  int n = 0;
  int p = 0;
  int curSel = 0;
  always @(negedge clk) begin
    logic eb, ec, ed;
    int cpuPer, dbgPer;
    if (!rstN) begin
      n = 0; p = 0; curSel = 0;
      expQ.push_back(3'b000);
      tagQ.push_back("R1 reset");
    end else begin
      cpuPer = 4 << curSel;
      dbgPer = 2 << curSel;
      eb = ((n % 4) == 3);
      ec = (p == cpuPer - 1);
      ed = ((p % dbgPer) == dbgPer - 1) && !dbgDisable;
      expQ.push_back({eb, ec, ed});
      tagQ.push_back(tag);
      n++;
      if (ec) begin
        p = 0;
        curSel = int'(divSel);
      end else begin
        p++;
      end
    end
  end

  // Monitor: pops the expected triple and compares against the ports.
  always @(negedge clk) begin
    logic [2:0] e;
    string t;
    #1;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (baseEn !== e[2]) begin
        bad++;
        $display("FAIL R1 [%s] baseEn actual=%b expected=%b cycle=%0d", t, baseEn, e[2], cycles);
      end
      total++;
      if (cpuEn !== e[1]) begin
        bad++;
        $display("FAIL R2 [%s] cpuEn actual=%b expected=%b cycle=%0d", t, cpuEn, e[1], cycles);
      end
      total++;
      if (dbgEn !== e[0]) begin
        bad++;
        $display("FAIL R5 [%s] dbgEn actual=%b expected=%b cycle=%0d", t, dbgEn, e[0], cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input int sel, input bit dis, input string t, input int cyc);
    @(posedge clk);
    #2;
    divSel = 3'(sel);
    dbgDisable = dis;
    tag = t;
    repeat (cyc) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2;
    rstN = 1'b1;
    tag = "R3 R6";
    repeat (40) @(posedge clk);
    drive(0, 1'b1, "R7 sel0", 13);
    drive(0, 1'b0, "R6", 6);
    drive(2, 1'b0, "R8 to sel2", 101);
    drive(1, 1'b0, "R9 sel1", 97);
    drive(1, 1'b1, "R7 sel1", 21);
    drive(7, 1'b0, "R4 sel7", 1200);
    drive(3, 1'b0, "R2 sel3", 150);
    drive(3, 1'b1, "R7 sel3", 37);
    drive(5, 1'b0, "R5 sel5", 301);
    drive(0, 1'b0, "R8 to sel0", 200);
    @(negedge clk);
    #3;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule